// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle 32-bit RISC core in which one memory port, one ALU and a set of holding registers (instruction, operand A/B, ALU result, memory data) are reused across several clock cycles per instruction. It is a Moore state machine. Each state drives a fixed pattern on the datapath control lines. The only input it looks at is the 6-bit opcode field of the instruction register, and only while it is in the decode state.

Every instruction begins with a fetch step and then a decode/register-read step. The fetch step reads memory at the PC, loads the instruction register and advances the PC by 4. The decode step lets the ALU form a speculative branch target from the PC and the shifted, sign-extended offset. Register-register ALU instructions then take an execute step and a write-back step. Word loads instead take an address step, a memory-read step and a write-back step. Any other opcode sends the machine straight back to fetch without writing anything.

Top module: `mc_ctrl_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in the fetch state from any state. On the cycle after the edge that samples `rst` high, the outputs carry the fetch pattern.
- R2: Fetch pattern: `mem_rd`=1, `ir_load`=1, `pc_load`=1, `addr_sel_data`=0, `pc_src`=01, `alu_class`=00, `opa_sel`=0 (PC), `opb_sel`=01 (constant 4). Every other output is 0.
- R3: Decode always follows fetch. Its pattern is `opa_sel`=0, `opb_sel`=11 (sign-extended immediate shifted left by 2) and `alu_class`=00. Every other output is 0.
- R4: When the opcode is 000000 during decode, the next state is R-type execute: `opa_sel`=1 (register A), `opb_sel`=00 (register B), `alu_class`=10 (operation chosen by the function field). Every other output is 0.
- R5: R-type write-back follows execute: `rf_we`=1, `wb_sel_mem`=0 (ALU result), `dst_sel_rd`=1 (rd field). Every other output is 0.
- R6: When the opcode is 100011 during decode, the next state is load address: `opa_sel`=1, `opb_sel`=10 (sign-extended immediate), `alu_class`=00. Every other output is 0.
- R7: The load memory step follows the address step: `addr_sel_data`=1 (address from ALU result), `mem_rd`=1. Every other output is 0.
- R8: Load write-back follows the memory step: `rf_we`=1, `wb_sel_mem`=1 (memory data), `dst_sel_rd`=0 (rt field). Every other output is 0.
- R9: Any opcode other than 000000 and 100011 during decode returns the sequencer to fetch on the next cycle. No register-file write and no data-memory read take place.
- R10: An R-type instruction takes exactly 4 cycles and a load exactly 5. The cycle after either write-back is a fetch. The opcode is ignored in every state except decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| addr_sel_data | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read enable |
| ir_load | output | 1 | Instruction register write enable |
| pc_load | output | 1 | PC write enable |
| pc_src | output | 2 | PC next-value source select |
| alu_class | output | 2 | ALU operation class: 00 add, 10 function-field |
| opa_sel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| opb_sel | output | 2 | ALU operand B: 00 B, 01 four, 10 immediate, 11 immediate<<2 |
| rf_we | output | 1 | Register file write enable |
| wb_sel_mem | output | 1 | Write-back source: 0 = ALU result, 1 = memory data |
| dst_sel_rd | output | 1 | Destination register field: 0 = rt, 1 = rd |

## Verification
The hardest behaviour to reach from the ports is that the opcode is sampled only in decode. A faulty sequencer that reads the opcode in another state still looks correct if the opcode is held steady. The stimulus therefore drives a scrambled opcode in every non-decode cycle and the real one only during decode, for each of the 64 opcodes in turn. A reset is also asserted in the middle of a load, to show that the sequence is abandoned and fetch resumes.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OPC_W  = 6;
    localparam int SEL_W  = 2;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;

    typedef enum logic [2:0] {
        ST_FETCH   = 3'd0,
        ST_DECODE  = 3'd1,
        ST_RX_EXEC = 3'd2,
        ST_RX_WB   = 3'd3,
        ST_LD_ADDR = 3'd4,
        ST_LD_MEM  = 3'd5,
        ST_LD_WB   = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic             addr_sel_data;
        logic             mem_rd;
        logic             ir_load;
        logic             pc_load;
        logic [SEL_W-1:0] pc_src;
        logic [SEL_W-1:0] alu_class;
        logic             opa_sel;
        logic [SEL_W-1:0] opb_sel;
        logic             rf_we;
        logic             wb_sel_mem;
        logic             dst_sel_rd;
    } ctrl_t;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

    localparam logic [SEL_W-1:0] OPB_REG   = 2'b00;
    localparam logic [SEL_W-1:0] OPB_FOUR  = 2'b01;
    localparam logic [SEL_W-1:0] OPB_IMM   = 2'b10;
    localparam logic [SEL_W-1:0] OPB_IMMSH = 2'b11;

    localparam logic [SEL_W-1:0] ALU_ADD   = 2'b00;
    localparam logic [SEL_W-1:0] ALU_FUNCT = 2'b10;

    localparam logic [SEL_W-1:0] PCS_INC   = 2'b01;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
    import mc_ctrl_pkg::*;
#(
    parameter logic [OPC_W-1:0] RTYPE_CODE = OPC_RTYPE,
    parameter logic [OPC_W-1:0] LOAD_CODE  = OPC_LOAD
) (
    input  seq_state_e       cur,
    input  logic [OPC_W-1:0] opcode,
    output seq_state_e       nxt
);

    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:   nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == RTYPE_CODE)
                    nxt = ST_RX_EXEC;
                else if (opcode == LOAD_CODE)
                    nxt = ST_LD_ADDR;
                else
                    nxt = ST_FETCH;
            end
            ST_RX_EXEC: nxt = ST_RX_WB;
            ST_RX_WB:   nxt = ST_FETCH;
            ST_LD_ADDR: nxt = ST_LD_MEM;
            ST_LD_MEM:  nxt = ST_LD_WB;
            ST_LD_WB:   nxt = ST_FETCH;
            default:    nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  seq_state_e cur,
    output ctrl_t      ctl
);

    always_comb begin
        ctl = '0;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_load   = 1'b1;
                ctl.pc_load   = 1'b1;
                ctl.pc_src    = PCS_INC;
                ctl.alu_class = ALU_ADD;
                ctl.opb_sel   = OPB_FOUR;
            end
            ST_DECODE: begin
                ctl.alu_class = ALU_ADD;
                ctl.opb_sel   = OPB_IMMSH;
            end
            ST_RX_EXEC: begin
                ctl.opa_sel   = 1'b1;
                ctl.opb_sel   = OPB_REG;
                ctl.alu_class = ALU_FUNCT;
            end
            ST_RX_WB: begin
                ctl.rf_we      = 1'b1;
                ctl.dst_sel_rd = 1'b1;
            end
            ST_LD_ADDR: begin
                ctl.opa_sel   = 1'b1;
                ctl.opb_sel   = OPB_IMM;
                ctl.alu_class = ALU_ADD;
            end
            ST_LD_MEM: begin
                ctl.addr_sel_data = 1'b1;
                ctl.mem_rd        = 1'b1;
            end
            ST_LD_WB: begin
                ctl.rf_we      = 1'b1;
                ctl.wb_sel_mem = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
    import mc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic             addr_sel_data,
    output logic             mem_rd,
    output logic             ir_load,
    output logic             pc_load,
    output logic [SEL_W-1:0] pc_src,
    output logic [SEL_W-1:0] alu_class,
    output logic             opa_sel,
    output logic [SEL_W-1:0] opb_sel,
    output logic             rf_we,
    output logic             wb_sel_mem,
    output logic             dst_sel_rd
);

    seq_regs_t  regs_d, regs_q;
    seq_state_e state_nxt;
    ctrl_t      ctl;

    mc_ctrl_next #(
        .RTYPE_CODE (OPC_RTYPE),
        .LOAD_CODE  (OPC_LOAD)
    ) u_next (
        .cur    (regs_q.state),
        .opcode (opcode),
        .nxt    (state_nxt)
    );

    mc_ctrl_decode u_dec (
        .cur (regs_q.state),
        .ctl (ctl)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = state_nxt;
        if (rst)
            regs_d.state = ST_FETCH;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign addr_sel_data = ctl.addr_sel_data;
    assign mem_rd        = ctl.mem_rd;
    assign ir_load       = ctl.ir_load;
    assign pc_load       = ctl.pc_load;
    assign pc_src        = ctl.pc_src;
    assign alu_class     = ctl.alu_class;
    assign opa_sel       = ctl.opa_sel;
    assign opb_sel       = ctl.opb_sel;
    assign rf_we         = ctl.rf_we;
    assign wb_sel_mem    = ctl.wb_sel_mem;
    assign dst_sel_rd    = ctl.dst_sel_rd;

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ir_load && pc_load && mem_rd));

    // R2
    fetch_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        ir_load |-> (pc_load && mem_rd && !addr_sel_data && opb_sel == OPB_FOUR && !rf_we));

    // R3
    decode_follows_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> (opb_sel == OPB_IMMSH && !opa_sel && !mem_rd && !rf_we));

    // R5
    rx_wb_after_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_we && !wb_sel_mem) |-> $past(opa_sel && opb_sel == OPB_REG && alu_class == ALU_FUNCT));

    // R8
    ld_wb_after_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_we && wb_sel_mem) |-> $past(addr_sel_data && mem_rd));

    // R10
    wb_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> ir_load);

    // R9
    no_write_after_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (opb_sel == OPB_IMMSH) |=> !rf_we && !addr_sel_data);

    // R10
    exclusive_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ir_load, rf_we, addr_sel_data}));

endmodule

// File: tb/sim_mc_ctrl_seq.sv
module sim_mc_ctrl_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       addr_sel_data, mem_rd, ir_load, pc_load;
    logic [1:0] pc_src, alu_class, opb_sel;
    logic       opa_sel, rf_we, wb_sel_mem, dst_sel_rd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam int S_F = 0, S_D = 1, S_E = 2, S_RW = 3, S_A = 4, S_M = 5, S_LW = 6;

    always #10 clk = ~clk;

    mc_ctrl_seq u0 (
        .clk(clk), .rst(rst), .opcode(opcode),
        .addr_sel_data(addr_sel_data), .mem_rd(mem_rd), .ir_load(ir_load),
        .pc_load(pc_load), .pc_src(pc_src), .alu_class(alu_class),
        .opa_sel(opa_sel), .opb_sel(opb_sel), .rf_we(rf_we),
        .wb_sel_mem(wb_sel_mem), .dst_sel_rd(dst_sel_rd)
    );

    // bit order: addr_sel,mem_rd,ir_load,pc_load,pc_src[2],alu_class[2],opa,opb[2],rf_we,wb_mem,dst_rd
    function automatic logic [13:0] expect_vec(int s);
        case (s)
            S_F:     return 14'b0_1_1_1_01_00_0_01_0_0_0;
            S_D:     return 14'b0_0_0_0_00_00_0_11_0_0_0;
            S_E:     return 14'b0_0_0_0_00_10_1_00_0_0_0;
            S_RW:    return 14'b0_0_0_0_00_00_0_00_1_0_1;
            S_A:     return 14'b0_0_0_0_00_00_1_10_0_0_0;
            S_M:     return 14'b1_1_0_0_00_00_0_00_0_0_0;
            default: return 14'b0_0_0_0_00_00_0_00_1_1_0;
        endcase
    endfunction

    task automatic check(int s, string tag, int op);
        logic [13:0] act, exp_v;
        act = {addr_sel_data, mem_rd, ir_load, pc_load, pc_src, alu_class,
               opa_sel, opb_sel, rf_we, wb_sel_mem, dst_sel_rd};
        exp_v = expect_vec(s);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s,R11 op=%b step=%0d actual=%b expected=%b", tag, op[5:0], s, act, exp_v);
        end
    endtask

    initial begin
        string ftag;
        logic [5:0] junk;
        repeat (2) @(negedge clk);
        check(S_F, "R1", 0);
        rst = 1'b0;
        ftag = "R2";
        for (int op = 0; op < 64; op++) begin
            junk = op[5:0] ^ 6'h2B;
            opcode = junk;
            check(S_F, ftag, op);
            @(negedge clk);
            opcode = op[5:0];
            check(S_D, "R3", op);
            @(negedge clk);
            opcode = junk;
            if (op == 0) begin
                check(S_E, "R4", op);
                @(negedge clk);
                opcode = 6'b100011;
                check(S_RW, "R5", op);
                @(negedge clk);
                ftag = "R10";
            end else if (op == 35) begin
                check(S_A, "R6", op);
                @(negedge clk);
                opcode = 6'b000000;
                check(S_M, "R7", op);
                @(negedge clk);
                opcode = 6'b000000;
                check(S_LW, "R8", op);
                @(negedge clk);
                ftag = "R10";
            end else begin
                ftag = "R9";
            end
        end
        // reset in the middle of a load
        opcode = 6'b100011;
        check(S_F, ftag, 35);
        @(negedge clk);
        check(S_D, "R3", 35);
        @(negedge clk);
        check(S_A, "R6", 35);
        rst = 1'b1;
        @(negedge clk);
        check(S_F, "R1", 35);
        rst = 1'b0;
        opcode = 6'b000000;
        @(negedge clk);
        check(S_D, "R1", 0);
        @(negedge clk);
        check(S_E, "R4", 0);
        @(negedge clk);
        check(S_RW, "R5", 0);
        @(negedge clk);
        check(S_F, "R10", 0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule